// File: doc/BRIEF.md
# Transaction Clock-Domain Bridge

This block moves one bus transaction at a time from a source clock domain, where an external-bus front end produces commands, into an unrelated system clock domain, and carries the completion back. The source issues a single-cycle request together with a packed 48-bit command word. The bridge registers the command word and holds it stable. Only one request level crosses the boundary.

In the system domain the bridge decodes the command into either a one-cycle write strobe or a one-cycle read strobe, with the address and write data alongside. For a read, it captures the returned data one system cycle later. It then raises an acknowledge level that crosses back. The source side turns that level into a one-cycle acknowledge pulse with the 32-bit response. The handshake is four-phase, so both domains are idle again before a new request is accepted.

Top module: `txn_cdc_bridge`

## Requirements
- R1: The command word `src_payload` is laid out as bit 47 = write flag, bit 46 = read flag, bits 45:32 = word address, bits 31:16 = upper data half, bits 15:0 = lower data half. It is captured in the cycle `src_req` is high, so later changes to `src_payload` have no effect on that transaction. `dst_addr` carries bits 45:32 and `dst_wdata` carries bits 31:0.
- R2: A command with the write flag set gives exactly one `dst_wr_en` pulse, one system cycle wide, with `dst_addr` and `dst_wdata` valid in that cycle. It gives no `dst_rd_en`.
- R3: A command with only the read flag set gives exactly one `dst_rd_en` pulse, one system cycle wide. `dst_rdata` is sampled at the end of the system cycle that follows the pulse. That value is returned as `src_rsp`.
- R4: `src_ack` is high for exactly one source cycle per accepted request. `src_rsp` changes only in that cycle and keeps its value until the next acknowledge.
- R5: A request that arrives before the previous handshake has returned to idle in both domains is ignored. It produces no strobe and no acknowledge.
- R6: A command with both flags set is performed as a write only. A command with neither flag set produces no strobe but is still acknowledged.
- R7: While either reset is asserted, and after its release, `src_ack`, `dst_wr_en` and `dst_rd_en` are low until a request arrives. The resets are asynchronous active-low and are released synchronously in each domain.
- R8: Transfers are correct when the system clock is slower than, equal to, or faster than the source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source-domain clock |
| src_rst_n | input | 1 | Source-domain reset, active low |
| src_req | input | 1 | One-cycle request pulse |
| src_payload | input | 48 | Packed command word (R1) |
| src_ack | output | 1 | One-cycle completion pulse |
| src_rsp | output | 32 | Response data, valid with and after `src_ack` |
| dst_clk | input | 1 | System-domain clock |
| dst_rst_n | input | 1 | System-domain reset, active low |
| dst_addr | output | 14 | System word address |
| dst_wr_en | output | 1 | One-cycle write strobe |
| dst_wdata | output | 32 | System write data |
| dst_rd_en | output | 1 | One-cycle read strobe |
| dst_rdata | input | 32 | System read data |

## Verification
A strobe follows a request by about three system cycles: two synchronizer stages and one output register. Read data is due exactly one system cycle after the strobe. The acknowledge follows the rise of the acknowledge level by about three source cycles. Because these counts shift with the clock ratio, the bench waits for `src_ack` on falling source edges with a bounded wait, instead of assuming a fixed latency.

The bench's system-side model puts valid read data on `dst_rdata` only in the one cycle after the read strobe and drives a marker value at all other times. A capture in any other cycle therefore returns the wrong response. Strobe counts are taken on every rising system edge. They are compared only after each handshake has been given time to return to idle, so one pulse per command and one cycle per pulse are confirmed at that point.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE      = 2'd0,
    SRC_WAIT_ACK  = 2'd1,
    SRC_WAIT_DROP = 2'd2
  } src_state_t;

  typedef enum logic [1:0] {
    DST_IDLE   = 2'd0,
    DST_STROBE = 2'd1,
    DST_SETTLE = 2'd2,
    DST_HOLD   = 2'd3
  } dst_state_t;
endpackage

// File: rtl/bridge_sync.sv
module bridge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/bridge_src.sv
module bridge_src
  import bridge_pkg::*;
#(
  parameter int PAY_W  = 48,
  parameter int RSP_W  = 32,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [PAY_W-1:0] payload,
  input  logic             ack_lvl_x,
  input  logic [RSP_W-1:0] rsp_x,
  output logic             req_lvl,
  output logic [PAY_W-1:0] pay_hold,
  output logic             ack,
  output logic [RSP_W-1:0] rsp
);
  src_state_t state_q, state_d;
  logic       req_lvl_d;
  logic       load, take;
  logic       ack_s;

  bridge_sync #(.STAGES(SYNC_N)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(ack_lvl_x), .q(ack_s)
  );

  always_comb begin
    state_d   = state_q;
    req_lvl_d = req_lvl;
    load      = 1'b0;
    take      = 1'b0;
    case (state_q)
      SRC_IDLE: if (req) begin
        state_d   = SRC_WAIT_ACK;
        req_lvl_d = 1'b1;
        load      = 1'b1;
      end
      SRC_WAIT_ACK: if (ack_s) begin
        state_d   = SRC_WAIT_DROP;
        req_lvl_d = 1'b0;
        take      = 1'b1;
      end
      SRC_WAIT_DROP: if (!ack_s) state_d = SRC_IDLE;
      default: begin
        state_d   = SRC_IDLE;
        req_lvl_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SRC_IDLE;
      req_lvl  <= 1'b0;
      ack      <= 1'b0;
      pay_hold <= '0;
      rsp      <= '0;
    end else begin
      state_q <= state_d;
      req_lvl <= req_lvl_d;
      ack     <= take;
      if (load) pay_hold <= payload;
      if (take) rsp      <= rsp_x;
    end
  end
endmodule

// File: rtl/bridge_dst.sv
module bridge_dst
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32,
  parameter int SYNC_N = 2,
  localparam int PAY_W = 2 + ADDR_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_lvl_x,
  input  logic [PAY_W-1:0]  pay_x,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wdata,
  output logic              rd_en,
  output logic              ack_lvl,
  output logic [DATA_W-1:0] rsp_hold
);
  localparam int WR_BIT = PAY_W - 1;
  localparam int RD_BIT = PAY_W - 2;
  localparam int A_TOP  = PAY_W - 3;

  dst_state_t state_q, state_d;
  logic       req_s;
  logic       launch, capture, ack_d;
  logic       is_rd_q;
  logic       want_wr, want_rd;

  bridge_sync #(.STAGES(SYNC_N)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d(req_lvl_x), .q(req_s)
  );

  // write wins when both flags are set
  assign want_wr = pay_x[WR_BIT];
  assign want_rd = pay_x[RD_BIT] & ~pay_x[WR_BIT];

  always_comb begin
    state_d = state_q;
    ack_d   = ack_lvl;
    launch  = 1'b0;
    capture = 1'b0;
    case (state_q)
      DST_IDLE: if (req_s) begin
        state_d = DST_STROBE;
        launch  = 1'b1;
      end
      DST_STROBE: state_d = DST_SETTLE;
      DST_SETTLE: begin
        state_d = DST_HOLD;
        ack_d   = 1'b1;
        capture = is_rd_q;
      end
      DST_HOLD: if (!req_s) begin
        state_d = DST_IDLE;
        ack_d   = 1'b0;
      end
      default: begin
        state_d = DST_IDLE;
        ack_d   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= DST_IDLE;
      ack_lvl  <= 1'b0;
      wr_en    <= 1'b0;
      rd_en    <= 1'b0;
      is_rd_q  <= 1'b0;
      addr     <= '0;
      wdata    <= '0;
      rsp_hold <= '0;
    end else begin
      state_q <= state_d;
      ack_lvl <= ack_d;
      wr_en   <= launch & want_wr;
      rd_en   <= launch & want_rd;
      if (launch) begin
        is_rd_q <= want_rd;
        addr    <= pay_x[A_TOP -: ADDR_W];
        wdata   <= pay_x[DATA_W-1:0];
      end
      if (capture) rsp_hold <= rdata;
    end
  end
endmodule

// File: rtl/txn_cdc_bridge.sv
module txn_cdc_bridge #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32,
  parameter int SYNC_N = 2,
  localparam int PAY_W = 2 + ADDR_W + DATA_W
) (
  input  logic              src_clk,
  input  logic              src_rst_n,
  input  logic              src_req,
  input  logic [PAY_W-1:0]  src_payload,
  output logic              src_ack,
  output logic [DATA_W-1:0] src_rsp,
  input  logic              dst_clk,
  input  logic              dst_rst_n,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              dst_wr_en,
  output logic [DATA_W-1:0] dst_wdata,
  output logic              dst_rd_en,
  input  logic [DATA_W-1:0] dst_rdata
);
  logic              src_rst_sn, dst_rst_sn;
  logic              req_lvl, ack_lvl;
  logic [PAY_W-1:0]  pay_hold;
  logic [DATA_W-1:0] rsp_hold;

  // reset asserted asynchronously, released on the local clock
  bridge_sync #(.STAGES(SYNC_N)) u_src_rst (
    .clk(src_clk), .rst_n(src_rst_n), .d(1'b1), .q(src_rst_sn)
  );
  bridge_sync #(.STAGES(SYNC_N)) u_dst_rst (
    .clk(dst_clk), .rst_n(dst_rst_n), .d(1'b1), .q(dst_rst_sn)
  );

  bridge_src #(.PAY_W(PAY_W), .RSP_W(DATA_W), .SYNC_N(SYNC_N)) u_src (
    .clk(src_clk), .rst_n(src_rst_sn), .req(src_req), .payload(src_payload),
    .ack_lvl_x(ack_lvl), .rsp_x(rsp_hold), .req_lvl(req_lvl),
    .pay_hold(pay_hold), .ack(src_ack), .rsp(src_rsp)
  );

  bridge_dst #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_N(SYNC_N)) u_dst (
    .clk(dst_clk), .rst_n(dst_rst_sn), .req_lvl_x(req_lvl), .pay_x(pay_hold),
    .rdata(dst_rdata), .addr(dst_addr), .wr_en(dst_wr_en), .wdata(dst_wdata),
    .rd_en(dst_rd_en), .ack_lvl(ack_lvl), .rsp_hold(rsp_hold)
  );
endmodule

// File: rtl/txn_cdc_bridge_chk.sv
module txn_cdc_bridge_chk #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32
) (
  input logic              src_clk,
  input logic              src_rst_n,
  input logic              src_ack,
  input logic [DATA_W-1:0] src_rsp,
  input logic              dst_clk,
  input logic              dst_rst_n,
  input logic              dst_wr_en,
  input logic              dst_rd_en,
  input logic [ADDR_W-1:0] dst_addr,
  input logic [DATA_W-1:0] dst_wdata
);
  AST_STROBE_EXCL: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    !(dst_wr_en && dst_rd_en)); // R6
  AST_WR_ONE_CYCLE: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_wr_en |=> !dst_wr_en); // R2
  AST_RD_ONE_CYCLE: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_rd_en |=> !dst_rd_en); // R3
  AST_CMD_HOLD: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    (dst_wr_en || dst_rd_en) |=> ($stable(dst_addr) && $stable(dst_wdata))); // R2
  AST_ACK_ONE_CYCLE: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    src_ack |=> !src_ack); // R4
  AST_RSP_HOLD: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    !src_ack |-> $stable(src_rsp)); // R4
endmodule

bind txn_cdc_bridge txn_cdc_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .src_clk(src_clk), .src_rst_n(src_rst_n), .src_ack(src_ack), .src_rsp(src_rsp),
  .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_wr_en(dst_wr_en),
  .dst_rd_en(dst_rd_en), .dst_addr(dst_addr), .dst_wdata(dst_wdata)
);

// File: tb/txn_cdc_bridge_test.sv
`timescale 1ns / 1ps
module txn_cdc_bridge_test;
  // vector: [55:48] system half period ns, [47:0] command word (R1 layout)
  localparam int NV = 10;
  localparam logic [55:0] VEC [NV] = '{
    {8'd5,  2'b10, 14'h0003, 32'hDEAD_BEEF},
    {8'd5,  2'b01, 14'h0003, 32'h1111_2222},
    {8'd2,  2'b10, 14'h3FFF, 32'hA5A5_0F0F},
    {8'd2,  2'b01, 14'h3FFF, 32'h3333_4444},
    {8'd17, 2'b10, 14'h0000, 32'h0000_FFFF},
    {8'd17, 2'b01, 14'h0000, 32'h5555_6666},
    {8'd3,  2'b11, 14'h0155, 32'h1234_5678},
    {8'd23, 2'b01, 14'h0155, 32'h7777_8888},
    {8'd23, 2'b10, 14'h2AAA, 32'hFFFF_0000},
    {8'd4,  2'b01, 14'h2AAA, 32'h9999_AAAA}
  };

  logic        src_clk = 1'b0, dst_clk = 1'b0;
  logic        src_rst_n = 1'b0, dst_rst_n = 1'b0;
  logic        src_req = 1'b0;
  logic [47:0] src_payload = '0;
  logic        src_ack;
  logic [31:0] src_rsp;
  logic [13:0] dst_addr;
  logic        dst_wr_en, dst_rd_en;
  logic [31:0] dst_wdata;
  logic [31:0] dst_rdata = 32'hBAD0_BAD0;
  int          dst_half = 5;

  int total = 0, bad = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [13:0] last_addr = '0;
  logic [31:0] last_wdata = '0;
  logic [31:0] sysmem [64];
  logic [31:0] expmem [64];

  txn_cdc_bridge uut (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_req(src_req),
    .src_payload(src_payload), .src_ack(src_ack), .src_rsp(src_rsp),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_addr(dst_addr),
    .dst_wr_en(dst_wr_en), .dst_wdata(dst_wdata), .dst_rd_en(dst_rd_en),
    .dst_rdata(dst_rdata)
  );

  always #5 src_clk = ~src_clk;
  always #(dst_half) dst_clk = ~dst_clk;

  // system-side model: read data valid only in the cycle after the strobe
  always @(posedge dst_clk) begin
    if (dst_wr_en) begin
      sysmem[dst_addr[5:0]] <= dst_wdata;
      wr_cnt     <= wr_cnt + 1;
      last_addr  <= dst_addr;
      last_wdata <= dst_wdata;
    end
    if (dst_rd_en) begin
      rd_cnt    <= rd_cnt + 1;
      last_addr <= dst_addr;
    end
    dst_rdata <= dst_rd_en ? sysmem[dst_addr[5:0]] : 32'hBAD0_BAD0;
  end

  task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [47:0] pl);
    @(negedge src_clk);
    src_req = 1'b1;
    src_payload = pl;
    @(negedge src_clk);
    src_req = 1'b0;
    src_payload = ~pl; // later changes must not matter (R1)
  endtask

  task automatic wait_ack(output bit got, output logic [31:0] rsp);
    got = 1'b0;
    rsp = '0;
    for (int i = 0; i < 600 && !got; i++) begin
      @(negedge src_clk);
      if (src_ack) begin
        got = 1'b1;
        rsp = src_rsp;
      end
    end
  endtask

  initial begin
    #1_500_000;
    bad++;
    total++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit          got;
    logic [31:0] rsp;
    int          w0, r0;
    for (int i = 0; i < 64; i++) begin sysmem[i] = '0; expmem[i] = '0; end

    // R7: reset state
    repeat (4) @(negedge src_clk);
    chk(src_ack == 1'b0 && dst_wr_en == 1'b0 && dst_rd_en == 1'b0, "R7 in reset",
        {src_ack, dst_wr_en, dst_rd_en}, 0);
    src_rst_n = 1'b1;
    dst_rst_n = 1'b1;
    repeat (10) @(negedge src_clk);
    chk(src_ack == 1'b0 && wr_cnt == 0 && rd_cnt == 0, "R7 after release",
        {src_ack, wr_cnt[7:0], rd_cnt[7:0]}, 0);

    // table walk: R1 R2 R3 R4 R6 R8 across clock ratios
    for (int v = 0; v < NV; v++) begin
      logic [47:0] pl;
      bit do_wr, do_rd;
      pl = VEC[v][47:0];
      do_wr = pl[47];
      do_rd = pl[46] && !pl[47];
      dst_half = int'(VEC[v][55:48]);
      repeat (4) @(negedge src_clk);
      w0 = wr_cnt; r0 = rd_cnt;
      issue(pl);
      wait_ack(got, rsp);
      chk(got, "R8 ack arrives", {47'd0, got}, 1);
      @(negedge src_clk);
      chk(src_ack == 1'b0, "R4 ack one cycle", {47'd0, src_ack}, 0);
      repeat (60) @(negedge src_clk);
      chk(wr_cnt - w0 == (do_wr ? 1 : 0), "R2 write strobe count", 48'(wr_cnt - w0), do_wr ? 1 : 0);
      chk(rd_cnt - r0 == (do_rd ? 1 : 0), "R3 read strobe count", 48'(rd_cnt - r0), do_rd ? 1 : 0);
      chk(last_addr == pl[45:32], "R1 address field", 48'(last_addr), 48'(pl[45:32]));
      if (do_wr) begin
        chk(last_wdata == pl[31:0], "R1 write data field", 48'(last_wdata), 48'(pl[31:0]));
        expmem[pl[37:32]] = pl[31:0];
        if (pl[46]) chk(rd_cnt == r0, "R6 both flags write only", 48'(rd_cnt - r0), 0);
      end
      if (do_rd)
        chk(rsp == expmem[pl[37:32]], "R3 read response", 48'(rsp), 48'(expmem[pl[37:32]]));
    end

    // R4: response held after the acknowledge
    repeat (5) @(negedge src_clk);
    chk(src_rsp == 32'hFFFF_0000, "R4 response held", 48'(src_rsp), 48'hFFFF_0000);

    // R5: second request while busy is ignored
    dst_half = 11;
    repeat (4) @(negedge src_clk);
    w0 = wr_cnt;
    issue({2'b10, 14'h0010, 32'hCAFE_0001});
    @(negedge src_clk);
    src_req = 1'b1;
    src_payload = {2'b10, 14'h0011, 32'hCAFE_0002};
    @(negedge src_clk);
    src_req = 1'b0;
    wait_ack(got, rsp);
    chk(got, "R5 first request acked", {47'd0, got}, 1);
    got = 1'b0;
    for (int i = 0; i < 80; i++) begin
      @(negedge src_clk);
      if (src_ack) got = 1'b1;
    end
    chk(!got, "R5 no second ack", {47'd0, got}, 0);
    chk(wr_cnt - w0 == 1, "R5 single write", 48'(wr_cnt - w0), 1);
    chk(last_addr == 14'h0010, "R5 first address kept", 48'(last_addr), 48'h10);

    // R6: neither flag -> no strobe, still acknowledged
    w0 = wr_cnt; r0 = rd_cnt;
    issue({2'b00, 14'h0020, 32'h0BAD_F00D});
    wait_ack(got, rsp);
    chk(got, "R6 no-flag acked", {47'd0, got}, 1);
    repeat (60) @(negedge src_clk);
    chk(wr_cnt == w0 && rd_cnt == r0, "R6 no-flag no strobe",
        48'((wr_cnt - w0) + (rd_cnt - r0)), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule